// File: doc/BRIEF.md
# Flag-Setting Byte ALU with Short-Immediate and Compare Modes

This block is the arithmetic and logic stage of a small register-to-register processor. Each cycle it may accept one operation. The operation carries a function code, two byte operands, a four-bit immediate and the processor's current carry flag. One cycle later the block returns the byte result, the negative, zero and carry flags, and a write-enable that tells the register file whether the destination should be updated. The block holds no flag state of its own. The caller keeps the flags and feeds carry back in on the next operation.

Two operand forms are supported. In register form, the second operand comes from a second source register. In immediate form, the first operand is the destination register's value and the second operand is the four-bit immediate, padded with zeros to the data width. A separate compare mode always performs a subtraction of the second operand from the first and updates the flags, but never requests a write. Testing a register against zero is compare mode with an immediate of 0.

Top module: `alu8_flagged`

## Requirements
- R1: While reset is asserted, and until the first operation completes, `res_valid`, `wr_en`, `result` and all three flags are 0.
- R2: An operation presented with `op_valid`=1 on a rising edge shows its outputs, with `res_valid`=1, after exactly that edge; after an edge with `op_valid`=0, `res_valid` is 0.
- R3: OR (code 0), AND (code 1) and XOR (code 2) combine the two operands bitwise. NOT (code 3) inverts operand A and ignores operand B. All four pass `carry_in` through unchanged to C.
- R4: ADD (code 4) gives {C,result} = A + B. ADC (code 11) gives {C,result} = A + B + carry_in.
- R5: SUB (code 5) computes A + ~B + 1, and SBC (code 12) computes A + ~B + carry_in. C is the carry out of the top bit, so C=1 means no borrow.
- R6: With `imm_mode`=1, operand B is `imm` zero-extended to 8 bits and `opb` has no effect. Operand A stays `opa`, the destination value, so SUB yields opa minus imm.
- R7: ASL (code 6) shifts left by one bit, filling bit 0 with 0. LSR (code 8) shifts right by one bit, filling bit 7 with 0. In both, C receives the bit shifted out.
- R8: ASR (code 9) shifts right by one bit, keeps bit 7 unchanged, and sets C to the old bit 0.
- R9: ROL (code 7) and ROR (code 10) rotate by one bit through carry. `carry_in` enters the vacated bit, and the bit that leaves becomes C.
- R10: For every operation, N equals result bit 7 and Z is 1 exactly when the 8-bit result is 0.
- R11: With `cmp_mode`=1, the block computes A + ~B + 1 regardless of `func` and sets the flags as SUB would, and `wr_en` is 0.
- R12: Reserved codes 13 to 15 give result = A, C = carry_in and `wr_en` = 0.
- R13: Codes 0 to 12 with `cmp_mode`=0 give `wr_en` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| func | input | 4 | Function code |
| imm_mode | input | 1 | 1 selects the zero-extended immediate as operand B |
| cmp_mode | input | 1 | 1 selects compare: subtract, flags only, no write |
| opa | input | 8 | Operand A (first source register, or destination value in immediate form) |
| opb | input | 8 | Operand B in register form |
| imm | input | 4 | Short immediate |
| carry_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Outputs below belong to a completed operation |
| result | output | 8 | Result byte |
| wr_en | output | 1 | Destination register should be written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest case to reach is one where carry_in and the operand edge bits interact. A rotate must move a set carry into a byte that would otherwise be zero, or rotate out the only set bit to give Z=1 together with C=1. The subtract-with-carry path must be driven with carry_in cleared so that a borrow ripples. Directed vectors place 0x80 and 0x01 under ROL and ROR with each carry value, and feed SBC both carry states. Immediate-form and compare vectors hold deliberately non-zero upper bits on `opb` so that a leak of the register operand would change the result. A long run of random operations then covers the codes, modes and carries together.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam logic [3:0] FN_OR  = 4'd0;
   localparam logic [3:0] FN_AND = 4'd1;
   localparam logic [3:0] FN_XOR = 4'd2;
   localparam logic [3:0] FN_NOT = 4'd3;
   localparam logic [3:0] FN_ADD = 4'd4;
   localparam logic [3:0] FN_SUB = 4'd5;
   localparam logic [3:0] FN_ASL = 4'd6;
   localparam logic [3:0] FN_ROL = 4'd7;
   localparam logic [3:0] FN_LSR = 4'd8;
   localparam logic [3:0] FN_ASR = 4'd9;
   localparam logic [3:0] FN_ROR = 4'd10;
   localparam logic [3:0] FN_ADC = 4'd11;
   localparam logic [3:0] FN_SBC = 4'd12;

   typedef enum logic [1:0] {
      GRP_LOGIC = 2'd0,
      GRP_ARITH = 2'd1,
      GRP_SHIFT = 2'd2,
      GRP_NONE  = 2'd3
   } fn_group_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
   } alu_flags_t;

   function automatic fn_group_e group_of(input logic [3:0] f);
      case (f)
         FN_OR, FN_AND, FN_XOR, FN_NOT:         return GRP_LOGIC;
         FN_ADD, FN_SUB, FN_ADC, FN_SBC:        return GRP_ARITH;
         FN_ASL, FN_ROL, FN_LSR, FN_ASR, FN_ROR: return GRP_SHIFT;
         default:                               return GRP_NONE;
      endcase
   endfunction
endpackage

// File: rtl/alu8_opsel.sv
module alu8_opsel #(
   parameter int WIDTH = 8,
   parameter int IMM_W = 4
) (
   input  logic [WIDTH-1:0] opb,
   input  logic [IMM_W-1:0] imm,
   input  logic             imm_mode,
   output logic [WIDTH-1:0] b_eff
);
   localparam int PAD_W = WIDTH - IMM_W;

   logic [WIDTH-1:0] imm_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm};
      end else begin : g_full
         assign imm_ext = imm;
      end
   endgenerate

   assign b_eff = imm_mode ? imm_ext : opb;
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             subtract,
   input  logic             use_cin,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int EXT_W = WIDTH + 1;

   logic [WIDTH-1:0] b_x;
   logic             ci;
   logic [EXT_W-1:0] total;

   assign b_x   = subtract ? ~b : b;
   assign ci    = use_cin ? cin : subtract;
   assign total = {1'b0, a} + {1'b0, b_x} + {{WIDTH{1'b0}}, ci};
   assign sum   = total[WIDTH-1:0];
   assign cout  = total[WIDTH];
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic             cin,
   input  logic [3:0]       func,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   import alu8_pkg::*;

   always_comb begin
      res  = a;
      cout = cin;
      case (func)
         FN_ASL: begin res = {a[WIDTH-2:0], 1'b0};     cout = a[WIDTH-1]; end
         FN_ROL: begin res = {a[WIDTH-2:0], cin};      cout = a[WIDTH-1]; end
         FN_LSR: begin res = {1'b0, a[WIDTH-1:1]};     cout = a[0];       end
         FN_ASR: begin res = {a[WIDTH-1], a[WIDTH-1:1]}; cout = a[0];     end
         FN_ROR: begin res = {cin, a[WIDTH-1:1]};      cout = a[0];       end
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       func,
   output logic [WIDTH-1:0] res
);
   import alu8_pkg::*;

   always_comb begin
      case (func)
         FN_OR:   res = a | b;
         FN_AND:  res = a & b;
         FN_XOR:  res = a ^ b;
         FN_NOT:  res = ~a;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged #(
   parameter int WIDTH = 8,
   parameter int IMM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       func,
   input  logic             imm_mode,
   input  logic             cmp_mode,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [IMM_W-1:0] imm,
   input  logic             carry_in,
   output logic             res_valid,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c
);
   import alu8_pkg::*;

   initial begin
      assert (WIDTH >= 2) else $error("alu8_flagged: WIDTH must be at least 2");
      assert (IMM_W >= 1 && IMM_W <= WIDTH)
         else $error("alu8_flagged: IMM_W must lie in 1..WIDTH");
   end

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] logic_res, shift_res, arith_res;
   logic             shift_c, arith_c;
   logic             do_sub, do_cin;
   fn_group_e        grp;

   logic [WIDTH-1:0] res_d;
   logic             wr_d;
   alu_flags_t       flg_d;

   assign grp    = group_of(func);
   assign do_sub = cmp_mode || (func == FN_SUB) || (func == FN_SBC);
   assign do_cin = !cmp_mode && ((func == FN_ADC) || (func == FN_SBC));

   alu8_opsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
      .opb      (opb),
      .imm      (imm),
      .imm_mode (imm_mode),
      .b_eff    (b_eff)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .a    (opa),
      .b    (b_eff),
      .func (func),
      .res  (logic_res)
   );

   alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a        (opa),
      .b        (b_eff),
      .subtract (do_sub),
      .use_cin  (do_cin),
      .cin      (carry_in),
      .sum      (arith_res),
      .cout     (arith_c)
   );

   alu8_shift #(.WIDTH(WIDTH)) u_shift (
      .a    (opa),
      .cin  (carry_in),
      .func (func),
      .res  (shift_res),
      .cout (shift_c)
   );

   always_comb begin
      res_d   = opa;
      flg_d.c = carry_in;
      wr_d    = 1'b0;
      if (cmp_mode) begin
         res_d   = arith_res;
         flg_d.c = arith_c;
      end else begin
         case (grp)
            GRP_LOGIC: begin res_d = logic_res; flg_d.c = carry_in; wr_d = 1'b1; end
            GRP_ARITH: begin res_d = arith_res; flg_d.c = arith_c;  wr_d = 1'b1; end
            GRP_SHIFT: begin res_d = shift_res; flg_d.c = shift_c;  wr_d = 1'b1; end
            default:   ;
         endcase
      end
      flg_d.n = res_d[WIDTH-1];
      flg_d.z = (res_d == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            result <= res_d;
            wr_en  <= wr_d;
            flag_n <= flg_d.n;
            flag_z <= flg_d.z;
            flag_c <= flg_d.c;
         end else begin
            wr_en  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk #(
   parameter int WIDTH = 8,
   parameter int IMM_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [3:0]       func,
   input logic             imm_mode,
   input logic             cmp_mode,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [IMM_W-1:0] imm,
   input logic             carry_in,
   input logic             res_valid,
   input logic [WIDTH-1:0] result,
   input logic             wr_en,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c
);
   import alu8_pkg::*;

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   // R2
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid && !wr_en);

   // R11
   cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && cmp_mode && !imm_mode |=>
         !wr_en && (flag_z == ($past(opa) == $past(opb))) && (flag_c == ($past(opa) >= $past(opb))));

   // R10
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> flag_n == result[WIDTH-1]);

   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> flag_z == (result == '0));

   // R4
   add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !cmp_mode && !imm_mode && func == FN_ADD |=>
         {flag_c, result} == ({1'b0, $past(opa)} + {1'b0, $past(opb)}));

   // R9
   rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !cmp_mode && func == FN_ROL |=>
         result[0] == $past(carry_in) && flag_c == $past(opa[WIDTH-1]));

   // R12
   reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !cmp_mode && func > FN_SBC |=>
         !wr_en && result == $past(opa) && flag_c == $past(carry_in));

   // R13
   write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !cmp_mode && func <= FN_SBC |=> wr_en);
endmodule

bind alu8_flagged alu8_flagged_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .func(func),
   .imm_mode(imm_mode), .cmp_mode(cmp_mode), .opa(opa), .opb(opb),
   .imm(imm), .carry_in(carry_in), .res_valid(res_valid), .result(result),
   .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/sim_alu8_flagged.sv
module sim_alu8_flagged;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] func = 4'd0;
   logic       imm_mode = 1'b0;
   logic       cmp_mode = 1'b0;
   logic [7:0] opa = 8'd0;
   logic [7:0] opb = 8'd0;
   logic [3:0] imm = 4'd0;
   logic       carry_in = 1'b0;
   logic       res_valid, wr_en, flag_n, flag_z, flag_c;
   logic [7:0] result;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [11:0] exp;   // {wr, n, z, c, result}
      string       req;
   } sb_item_t;

   sb_item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_flagged u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .func(func),
      .imm_mode(imm_mode), .cmp_mode(cmp_mode), .opa(opa), .opb(opb),
      .imm(imm), .carry_in(carry_in), .res_valid(res_valid), .result(result),
      .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
   );

   function automatic logic [11:0] model(input logic [3:0] f, input logic im,
                                         input logic cm, input logic [7:0] a,
                                         input logic [7:0] b, input logic [3:0] iv,
                                         input logic ci);
      logic [7:0] bb, r;
      logic [8:0] t;
      logic       c, w;
      bb = im ? {4'b0000, iv} : b;
      r = a; c = ci; w = 1'b1;
      if (cm) begin
         t = {1'b0, a} + {1'b0, ~bb} + 9'd1;
         r = t[7:0]; c = t[8]; w = 1'b0;
      end else begin
         case (f)
            4'd0:  r = a | bb;
            4'd1:  r = a & bb;
            4'd2:  r = a ^ bb;
            4'd3:  r = ~a;
            4'd4:  begin t = {1'b0, a} + {1'b0, bb};                  r = t[7:0]; c = t[8]; end
            4'd11: begin t = {1'b0, a} + {1'b0, bb} + {8'd0, ci};     r = t[7:0]; c = t[8]; end
            4'd5:  begin t = {1'b0, a} + {1'b0, ~bb} + 9'd1;          r = t[7:0]; c = t[8]; end
            4'd12: begin t = {1'b0, a} + {1'b0, ~bb} + {8'd0, ci};    r = t[7:0]; c = t[8]; end
            4'd6:  begin r = a << 1;               c = a[7]; end
            4'd7:  begin r = {a[6:0], ci};         c = a[7]; end
            4'd8:  begin r = a >> 1;               c = a[0]; end
            4'd9:  begin r = {a[7], a[7:1]};       c = a[0]; end
            4'd10: begin r = {ci, a[7:1]};         c = a[0]; end
            default: w = 1'b0;
         endcase
      end
      return {w, r[7], (r == 8'd0), c, r};
   endfunction

   task automatic apply(input logic [3:0] f, input logic im, input logic cm,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] iv, input logic ci, input string req);
      sb_item_t it;
      @(negedge clk);
      op_valid = 1'b1; func = f; imm_mode = im; cmp_mode = cm;
      opa = a; opb = b; imm = iv; carry_in = ci;
      it.exp = model(f, im, cm, a, b, iv, ci);
      it.req = req;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_valid = 1'b0;
         opa = 8'hA5; opb = 8'h5A; func = 4'd4; carry_in = 1'b1;
      end
   endtask

   // monitor: compares each completed operation against the queue head
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (sb.size() > 0) begin
               sb_item_t it;
               logic [11:0] got;
               it  = sb.pop_front();
               got = {wr_en, flag_n, flag_z, flag_c, result};
               vectors++;
               if (res_valid !== 1'b1 || got !== it.exp) begin
                  errors++;
                  $display("FAIL %s: got valid=%b {wr,n,z,c,res}=%h expected valid=1 %h",
                           it.req, res_valid, got, it.exp);
               end
            end else begin
               vectors++;
               if (res_valid !== 1'b0 || wr_en !== 1'b0) begin
                  errors++;
                  $display("FAIL R2: idle cycle got valid=%b wr=%b expected 0 0",
                           res_valid, wr_en);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2: watchdog expired, got hang expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      vectors++;
      if ({res_valid, wr_en, flag_n, flag_z, flag_c, result} !== 13'd0) begin
         errors++;
         $display("FAIL R1: reset outputs got %h expected 0",
                  {res_valid, wr_en, flag_n, flag_z, flag_c, result});
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R3 logic functions, carry passes through, NOT ignores B
      apply(4'd0, 0, 0, 8'hA0, 8'h0C, 4'h0, 1, "R3");
      apply(4'd1, 0, 0, 8'hF0, 8'h3C, 4'h0, 0, "R3");
      apply(4'd2, 0, 0, 8'hFF, 8'hFF, 4'h0, 1, "R3");
      apply(4'd3, 0, 0, 8'h0F, 8'hFF, 4'h0, 1, "R3");
      apply(4'd3, 0, 0, 8'hFF, 8'h00, 4'h0, 0, "R3");
      // R4 add, add with carry, wrap to zero
      apply(4'd4, 0, 0, 8'hFF, 8'h01, 4'h0, 0, "R4");
      apply(4'd4, 0, 0, 8'h40, 8'h40, 4'h0, 1, "R4");
      apply(4'd11, 0, 0, 8'hFE, 8'h01, 4'h0, 1, "R4");
      apply(4'd11, 0, 0, 8'h10, 8'h20, 4'h0, 0, "R4");
      // R5 subtract with and without borrow
      apply(4'd5, 0, 0, 8'h05, 8'h07, 4'h0, 1, "R5");
      apply(4'd5, 0, 0, 8'h07, 8'h07, 4'h0, 0, "R5");
      apply(4'd12, 0, 0, 8'h07, 8'h07, 4'h0, 0, "R5");
      apply(4'd12, 0, 0, 8'h07, 8'h05, 4'h0, 1, "R5");
      // R6 immediate form with junk on opb
      apply(4'd5, 1, 0, 8'h10, 8'hF0, 4'hF, 1, "R6");
      apply(4'd4, 1, 0, 8'hF8, 8'hFF, 4'h8, 0, "R6");
      apply(4'd0, 1, 0, 8'h00, 8'hF0, 4'h3, 0, "R6");
      // R7 shifts
      apply(4'd6, 0, 0, 8'h80, 8'h00, 4'h0, 0, "R7");
      apply(4'd6, 0, 0, 8'h41, 8'h00, 4'h0, 1, "R7");
      apply(4'd8, 0, 0, 8'h01, 8'h00, 4'h0, 1, "R7");
      apply(4'd8, 0, 0, 8'h82, 8'h00, 4'h0, 0, "R7");
      // R8 arithmetic shift right
      apply(4'd9, 0, 0, 8'h81, 8'h00, 4'h0, 0, "R8");
      apply(4'd9, 0, 0, 8'h40, 8'h00, 4'h0, 1, "R8");
      // R9 rotates through carry
      apply(4'd7, 0, 0, 8'h80, 8'h00, 4'h0, 0, "R9");
      apply(4'd7, 0, 0, 8'h80, 8'h00, 4'h0, 1, "R9");
      apply(4'd10, 0, 0, 8'h01, 8'h00, 4'h0, 0, "R9");
      apply(4'd10, 0, 0, 8'h01, 8'h00, 4'h0, 1, "R9");
      idle(1);
      // R11 compare: register, immediate, test-against-zero, func ignored
      apply(4'd0, 0, 1, 8'h33, 8'h33, 4'h0, 0, "R11");
      apply(4'd4, 0, 1, 8'h20, 8'h30, 4'h0, 1, "R11");
      apply(4'd9, 1, 1, 8'h00, 8'hAA, 4'h0, 0, "R11");
      apply(4'd15, 1, 1, 8'h85, 8'h00, 4'h0, 0, "R11");
      // R12 reserved codes
      apply(4'd13, 0, 0, 8'h00, 8'h12, 4'h0, 1, "R12");
      apply(4'd14, 0, 0, 8'h9C, 8'h12, 4'h0, 0, "R12");
      apply(4'd15, 1, 0, 8'h7F, 8'h12, 4'h5, 1, "R12");
      idle(2);
      // R10 R13 random mix over all codes and modes
      for (int i = 0; i < 400; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         apply(rv[3:0], rv[4], (rv[7:5] == 3'd0), rv[15:8], rv[23:16],
               rv[27:24], rv[28], "R10/R13 random");
         if (rv[31:29] == 3'd0) idle(1);
      end
      idle(3);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule